// File: doc/BRIEF.md
# Configuration Header With Per-Byte Write Masks

This block holds the 256-byte configuration space of a type-0 device function. Software reaches it through a small byte-addressed access port. Each access carries a start offset, a byte count of 1, 2 or 4, and a direction. Write data is taken least significant byte first, and each byte lands at the next higher offset.

Every byte has its own write-enable mask. Identification fields, status, reserved positions and the sizing bits of the address decoders therefore keep their values whatever software writes to them. The six base address decoders and the expansion ROM decoder take their writable bits from power-of-two region sizes given as parameters. Their type bits are loaded at reset.

Reads return the addressed bytes packed little-endian one cycle later. The block raises a one-cycle remap pulse when a write actually alters a byte that affects address decoding. Downstream logic can then rebuild its windows.

Top module: `cfgh_space`

## Requirements
- R1: After reset, offsets 0x00-0x03 hold `ID_WORD` (byte 0x00 = bits 7:0), offsets 0x08-0x0B hold `CLASS_REV` in the same order, offset 0x3D holds `INT_PIN`, and the low byte of each base decoder n (offset 0x10+4n) holds the 4-bit `BAR_TYPE[n]` in bits 3:0. Every other byte is 0x00, and `rd_valid` and `remap_pulse` are low.
- R2: A legal read (`acc_write`=0) raises `rd_valid` for exactly the next cycle. `rd_data` bits 8i+7:8i carry the byte at offset `acc_addr`+i for i < `acc_len`, and zero for the other lanes. `rd_valid` is low in every cycle that does not follow a legal read.
- R3: A legal write of length 1, 2 or 4 stores, at offset `acc_addr`+i, the value (old AND NOT mask) OR (`acc_wdata` byte i AND mask). Byte i is bits 8i+7:8i.
- R4: Header masks are as follows. Offset 0x04 is 0xFF and 0x05 is 0x07. Offsets 0x0C, 0x0D and 0x3C are 0xFF. Every byte from 0x40 to 0xFF is 0xFF. Every other header byte outside the decoder registers is 0x00.
- R5: Base decoder n at offset 0x10+4n has the 32-bit mask NOT(`BAR_SIZE[n]`-1), laid out little-endian. A decoder whose size is 0 is fully read-only.
- R6: The ROM decoder at 0x30-0x33 has the mask NOT(`ROM_SIZE`-1) OR 1, so bit 0 is the enable bit. A size of 0 makes it fully read-only.
- R7: Bytes of an access that would fall past offset 0xFF are neither written nor read. Their read lanes return zero.
- R8: An access whose `acc_len` is not 1, 2 or 4 has no effect. It stores nothing, gives no `rd_valid` and gives no `remap_pulse`.
- R9: `remap_pulse` is high for one cycle, in the cycle after a write that changes the stored value of at least one byte in 0x04-0x05, 0x10-0x27 or 0x30-0x33. Several changed bytes give a single pulse. A write that changes no such byte gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Start byte offset |
| acc_len | input | 3 | Byte count; 1, 2 or 4 are legal |
| acc_wdata | input | 32 | Write data, lowest byte to lowest offset |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | High the cycle after a legal read |
| remap_pulse | output | 1 | High the cycle after a write that changed a decoding byte |

## Verification
The bound checker watches the port protocol on every cycle. A legal read is followed by `rd_valid`, and writes and illegal lengths never produce it. A remap pulse only ever follows a legal write. Single-byte reads never carry data in the upper lanes. The stored values cannot be seen from the checker, so the bench shows them. It sweeps every offset with all-ones and all-zeros writes, and follows with random mixed-length traffic and reads against an arithmetic mask model. It also covers the wrap-off at 0xFF, the illegal lengths and the no-change writes that must stay silent.

// File: rtl/cfgh_pkg.sv
package cfgh_pkg;
    localparam int CFG_BYTES = 256;
    localparam int ADDR_W    = $clog2(CFG_BYTES);
    localparam int LANES     = 4;
    localparam int NUM_BARS  = 6;

    function automatic logic [7:0] byte_wmask(input logic [7:0] off,
                                              input logic [NUM_BARS-1:0][31:0] bar_size,
                                              input logic [31:0] rom_size);
        logic [31:0] m;
        logic [2:0]  n;
        logic [7:0]  r;
        r = 8'h00;
        m = 32'h0;
        n = 3'((off - 8'h10) >> 2);
        if (off >= 8'h40) r = 8'hFF;
        else if (off == 8'h04 || off == 8'h0C || off == 8'h0D || off == 8'h3C) r = 8'hFF;
        else if (off == 8'h05) r = 8'h07;
        else if (off >= 8'h10 && off < 8'h28) begin
            m = (bar_size[n] == 32'h0) ? 32'h0 : ~(bar_size[n] - 32'd1);
            r = m[8*off[1:0] +: 8];
        end else if (off >= 8'h30 && off < 8'h34) begin
            m = (rom_size == 32'h0) ? 32'h0 : (~(rom_size - 32'd1) | 32'h1);
            r = m[8*off[1:0] +: 8];
        end
        return r;
    endfunction

    function automatic logic [7:0] byte_reset(input logic [7:0] off,
                                              input logic [31:0] id_word,
                                              input logic [31:0] class_rev,
                                              input logic [7:0]  int_pin,
                                              input logic [NUM_BARS-1:0][3:0] bar_type);
        logic [2:0] n;
        logic [7:0] r;
        r = 8'h00;
        n = 3'((off - 8'h10) >> 2);
        if (off < 8'h04) r = id_word[8*off[1:0] +: 8];
        else if (off >= 8'h08 && off < 8'h0C) r = class_rev[8*off[1:0] +: 8];
        else if (off == 8'h3D) r = int_pin;
        else if (off >= 8'h10 && off < 8'h28 && off[1:0] == 2'b00) r = {4'h0, bar_type[n]};
        return r;
    endfunction

    function automatic logic is_decode_byte(input logic [7:0] off);
        return (off == 8'h04) || (off == 8'h05) ||
               (off >= 8'h10 && off < 8'h28) ||
               (off >= 8'h30 && off < 8'h34);
    endfunction
endpackage

// File: rtl/cfgh_table.sv
module cfgh_table
    import cfgh_pkg::*;
#(
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE  = '0,
    parameter logic [NUM_BARS-1:0][3:0]  BAR_TYPE  = '0,
    parameter logic [31:0]               ROM_SIZE  = 32'h0,
    parameter logic [31:0]               ID_WORD   = 32'h0,
    parameter logic [31:0]               CLASS_REV = 32'h0,
    parameter logic [7:0]                INT_PIN   = 8'h0
) (
    output logic [CFG_BYTES-1:0][7:0] wmask,
    output logic [CFG_BYTES-1:0][7:0] rstval,
    output logic [CFG_BYTES-1:0]      decode_sel
);
    for (genvar o = 0; o < CFG_BYTES; o++) begin : g_byte
        assign wmask[o]      = byte_wmask(8'(o), BAR_SIZE, ROM_SIZE);
        assign rstval[o]     = byte_reset(8'(o), ID_WORD, CLASS_REV, INT_PIN, BAR_TYPE);
        assign decode_sel[o] = is_decode_byte(8'(o));
    end
endmodule

// File: rtl/cfgh_lane.sv
module cfgh_lane
    import cfgh_pkg::*;
#(
    parameter int LANE = 0
) (
    input  logic [ADDR_W-1:0]         base,
    input  logic [2:0]                len,
    input  logic                      legal,
    input  logic [7:0]                wbyte,
    input  logic [CFG_BYTES-1:0][7:0] mem,
    input  logic [CFG_BYTES-1:0][7:0] wmask,
    input  logic [CFG_BYTES-1:0]      decode_sel,
    output logic                      en,
    output logic [ADDR_W-1:0]         idx,
    output logic [7:0]                old_byte,
    output logic [7:0]                new_byte,
    output logic                      decode_change
);
    logic [ADDR_W:0] sum;
    logic [7:0]      m;

    always_comb begin
        sum           = {1'b0, base} + (ADDR_W+1)'(LANE);
        idx           = sum[ADDR_W-1:0];
        en            = legal && (3'(LANE) < len) && !sum[ADDR_W];
        old_byte      = mem[idx];
        m             = wmask[idx];
        new_byte      = (old_byte & ~m) | (wbyte & m);
        decode_change = en && decode_sel[idx] && (new_byte != old_byte);
    end
endmodule

// File: rtl/cfgh_space.sv
module cfgh_space
    import cfgh_pkg::*;
#(
    parameter logic [NUM_BARS-1:0][31:0] BAR_SIZE  = {32'd0, 32'd4, 32'd0, 32'h0001_0000, 32'd256, 32'd4096},
    parameter logic [NUM_BARS-1:0][3:0]  BAR_TYPE  = {4'h0, 4'h1, 4'h0, 4'h8, 4'h1, 4'h0},
    parameter logic [31:0]               ROM_SIZE  = 32'h0000_0800,
    parameter logic [31:0]               ID_WORD   = 32'h5A17_C0DE,
    parameter logic [31:0]               CLASS_REV = 32'h0200_0003,
    parameter logic [7:0]                INT_PIN   = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [7:0]  acc_addr,
    input  logic [2:0]  acc_len,
    input  logic [31:0] acc_wdata,
    output logic [31:0] rd_data,
    output logic        rd_valid,
    output logic        remap_pulse
);
    typedef struct packed {
        logic [CFG_BYTES-1:0][7:0] mem;
        logic [8*LANES-1:0]        rdata;
        logic                      rvalid;
        logic                      remap;
    } state_t;

    state_t st_d, st_q;

    logic [CFG_BYTES-1:0][7:0] wmask, rstval;
    logic [CFG_BYTES-1:0]      decode_sel;
    logic                      legal;
    logic [LANES-1:0]          lane_en, lane_chg;
    logic [LANES-1:0][ADDR_W-1:0] lane_idx;
    logic [LANES-1:0][7:0]     lane_old, lane_new;

    assign legal = acc_len == 3'd1 || acc_len == 3'd2 || acc_len == 3'd4;

    cfgh_table #(
        .BAR_SIZE(BAR_SIZE), .BAR_TYPE(BAR_TYPE), .ROM_SIZE(ROM_SIZE),
        .ID_WORD(ID_WORD), .CLASS_REV(CLASS_REV), .INT_PIN(INT_PIN)
    ) u_table (
        .wmask(wmask), .rstval(rstval), .decode_sel(decode_sel)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        cfgh_lane #(.LANE(l)) u_lane (
            .base          (acc_addr),
            .len           (acc_len),
            .legal         (legal),
            .wbyte         (acc_wdata[8*l +: 8]),
            .mem           (st_q.mem),
            .wmask         (wmask),
            .decode_sel    (decode_sel),
            .en            (lane_en[l]),
            .idx           (lane_idx[l]),
            .old_byte      (lane_old[l]),
            .new_byte      (lane_new[l]),
            .decode_change (lane_chg[l])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.remap  = 1'b0;
        if (acc_valid && legal) begin
            if (acc_write) begin
                for (int l = 0; l < LANES; l++) begin
                    if (lane_en[l]) st_d.mem[lane_idx[l]] = lane_new[l];
                end
                st_d.remap = |lane_chg;
            end else begin
                st_d.rvalid = 1'b1;
                for (int l = 0; l < LANES; l++) begin
                    st_d.rdata[8*l +: 8] = lane_en[l] ? lane_old[l] : 8'h00;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mem    <= rstval;
            st_q.rdata  <= '0;
            st_q.rvalid <= 1'b0;
            st_q.remap  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data     = st_q.rdata;
    assign rd_valid    = st_q.rvalid;
    assign remap_pulse = st_q.remap;
endmodule

// File: rtl/cfgh_space_chk.sv
module cfgh_space_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_valid,
    input logic        acc_write,
    input logic [7:0]  acc_addr,
    input logic [2:0]  acc_len,
    input logic [31:0] rd_data,
    input logic        rd_valid,
    input logic        remap_pulse
);
    logic ok_len;
    assign ok_len = acc_len == 3'd1 || acc_len == 3'd2 || acc_len == 3'd4;

    // R2
    rd_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && ok_len) |=> rd_valid);

    // R2
    no_rd_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write) |=> !rd_valid);

    // R8
    illegal_len_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ok_len) |=> (!rd_valid && !remap_pulse));

    // R9
    remap_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write) |=> !remap_pulse);

    // R2
    idle_no_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!rd_valid && !remap_pulse));

    // R7
    single_byte_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && acc_len == 3'd1) |=> (rd_data[31:8] == 24'h0));
endmodule

bind cfgh_space cfgh_space_chk u_chk (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_len(acc_len), .rd_data(rd_data),
    .rd_valid(rd_valid), .remap_pulse(remap_pulse)
);

// File: tb/tb_cfgh_space.sv
module tb_cfgh_space;
    localparam logic [5:0][31:0] T_BAR_SIZE  = {32'd0, 32'd4, 32'd0, 32'h0001_0000, 32'd256, 32'd4096};
    localparam logic [5:0][3:0]  T_BAR_TYPE  = {4'h0, 4'h1, 4'h0, 4'h8, 4'h1, 4'h0};
    localparam logic [31:0]      T_ROM_SIZE  = 32'h800;
    localparam logic [31:0]      T_ID        = 32'h5A17_C0DE;
    localparam logic [31:0]      T_CLASS     = 32'h0200_0003;
    localparam logic [7:0]       T_PIN       = 8'h01;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0, acc_write = 1'b0;
    logic [7:0]  acc_addr = 8'h0;
    logic [2:0]  acc_len = 3'd1;
    logic [31:0] acc_wdata = 32'h0;
    logic [31:0] rd_data;
    logic        rd_valid, remap_pulse;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] model [256];

    always #10 clk = ~clk;

    cfgh_space #(
        .BAR_SIZE(T_BAR_SIZE), .BAR_TYPE(T_BAR_TYPE), .ROM_SIZE(T_ROM_SIZE),
        .ID_WORD(T_ID), .CLASS_REV(T_CLASS), .INT_PIN(T_PIN)
    ) dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_len(acc_len), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .rd_valid(rd_valid), .remap_pulse(remap_pulse)
    );

    function automatic logic [7:0] exp_mask(int off);
        longint sz, m;
        int n;
        if (off >= 64) return 8'hFF;
        if (off == 4 || off == 12 || off == 13 || off == 60) return 8'hFF;
        if (off == 5) return 8'h07;
        if (off >= 16 && off < 40) begin
            n = (off - 16) / 4;
            sz = longint'(T_BAR_SIZE[n]);
            m = (sz == 0) ? 0 : (64'h1_0000_0000 - sz);
            return 8'((m >> (8 * (off % 4))) & 255);
        end
        if (off >= 48 && off < 52) begin
            sz = longint'(T_ROM_SIZE);
            m = (sz == 0) ? 0 : ((64'h1_0000_0000 - sz) | 1);
            return 8'((m >> (8 * (off % 4))) & 255);
        end
        return 8'h00;
    endfunction

    function automatic bit is_decode(int off);
        return off == 4 || off == 5 || (off >= 16 && off < 40) || (off >= 48 && off < 52);
    endfunction

    function automatic string region_tag(int off);
        if (off >= 16 && off < 40) return "R5";
        if (off >= 48 && off < 52) return "R6";
        return "R4";
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic do_write(input int a, input int n, input logic [31:0] v);
        bit legal, exp_remap;
        logic [7:0] nb;
        legal = (n == 1 || n == 2 || n == 4);
        exp_remap = 0;
        if (legal) begin
            for (int i = 0; i < n; i++) begin
                if (a + i <= 255) begin
                    nb = (model[a+i] & ~exp_mask(a+i)) | (8'(v >> (8*i)) & exp_mask(a+i));
                    if (nb != model[a+i] && is_decode(a+i)) exp_remap = 1;
                    model[a+i] = nb;
                end
            end
        end
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_addr = 8'(a); acc_len = 3'(n); acc_wdata = v;
        @(negedge clk);
        acc_valid = 0;
        check(remap_pulse == exp_remap, legal ? "R9 remap" : "R8 remap", 32'(remap_pulse), 32'(exp_remap));
        check(rd_valid == 1'b0, "R2 no rd_valid on write", 32'(rd_valid), 0);
    endtask

    task automatic do_read(input int a, input int n, input string tag);
        bit legal;
        logic [31:0] exp;
        legal = (n == 1 || n == 2 || n == 4);
        exp = 0;
        if (legal)
            for (int i = 0; i < n; i++)
                if (a + i <= 255) exp[8*i +: 8] = model[a+i];
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_addr = 8'(a); acc_len = 3'(n);
        @(negedge clk);
        acc_valid = 0;
        if (legal) check(rd_valid && rd_data == exp, tag, rd_data, exp);
        else       check(!rd_valid && !remap_pulse, tag, 32'({rd_valid, remap_pulse}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int o = 0; o < 256; o++) model[o] = 8'h00;
        for (int i = 0; i < 4; i++) begin
            model[i]   = T_ID[8*i +: 8];
            model[8+i] = T_CLASS[8*i +: 8];
        end
        model[61] = T_PIN;
        for (int b = 0; b < 6; b++) model[16 + 4*b] = {4'h0, T_BAR_TYPE[b]};

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 outputs quiet after reset
        check(!rd_valid && !remap_pulse, "R1 outputs idle", 32'({rd_valid, remap_pulse}), 0);
        // R1 reset contents, word by word
        for (int w = 0; w < 64; w++) do_read(4*w, 4, "R1 reset value");

        // R4 R5 R6 sweep every offset with all-ones then all-zeros
        for (int o = 0; o < 256; o++) begin
            do_write(o, 1, 32'hFF);
            do_read(o, 1, region_tag(o));
            do_write(o, 1, 32'h00);
            do_read(o, 1, region_tag(o));
        end

        // R5 full-word sizing write, then an identical write gives no remap (R9)
        do_write(16, 4, 32'hFFFF_FFFF);
        do_read(16, 4, "R5 sizing word");
        do_write(16, 4, 32'hFFFF_FFFF);
        do_write(24, 4, 32'h1234_5678);
        do_read(24, 4, "R5 prefetch region");
        // R6 ROM enable bit and size mask
        do_write(48, 4, 32'hFFFF_FFFF);
        do_read(48, 4, "R6 rom word");
        do_write(48, 1, 32'h00);
        do_read(48, 2, "R6 rom enable cleared");

        // R7 truncation at the end of the space
        do_write(254, 4, 32'hAABB_CCDD);
        do_read(254, 4, "R7 truncated read");
        do_write(253, 4, 32'h1122_3344);
        do_read(252, 4, "R7 no wrap");
        do_read(0, 4, "R7 low bytes untouched");

        // R8 illegal lengths
        for (int n = 0; n < 8; n++) begin
            if (n != 1 && n != 2 && n != 4) begin
                do_write(64, n, 32'hDEAD_BEEF);
                do_read(64, 4, "R8 write ignored");
                do_read(64, n, "R8 illegal read");
            end
        end

        // R3 R2 R9 random mixed traffic
        for (int k = 0; k < 3000; k++) begin
            int a, n, sel;
            a = $urandom_range(0, 255);
            sel = $urandom_range(0, 2);
            n = (sel == 0) ? 1 : (sel == 1) ? 2 : 4;
            if ($urandom_range(0, 1) == 1) do_write(a, n, $urandom);
            else do_read(a, n, "R3 R2 random read");
        end
        for (int w = 0; w < 64; w++) do_read(4*w, 4, "R3 final contents");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule